// File: doc/BRIEF.md
# Paged Flash Array Controller

This block sequences program and erase work on a small nonvolatile-style byte array that is modelled in single-port on-chip RAM. A host fills a one-page staging buffer one byte at a time, then asks for a page program, a sector erase or a bulk erase. The controller walks the affected bytes through the RAM, one byte per cycle, and holds `busy` high for a fixed, parameterized number of cycles. These counts stand in for the long program and erase times of real flash.

Programming can only clear bits: each stored byte becomes the old value ANDed with the staged byte. Erasing sets every byte of one sector, or of the whole array, to FFh. There is no page erase. Reads go through an address pointer that advances after each byte. The default geometry is four sectors of four 128-byte pages, so that elaboration stays small. Setting `PAGES_PER_SECTOR` to 256 gives 131,072 bytes in 1,024 pages, with the sector chosen by address bits 16:15. All sizes are powers of two.

Top module: `pflash_ctrl`

## Requirements
- R1: After reset the controller fills the whole array with FFh while `busy` stays high for exactly ARRAY_BYTES cycles. During that time `done` and `rd_valid` are low.
- R2: When `ld_valid` is high and the block is idle, `ld_data` is written into the staging buffer at position `ld_addr[6:0]`. The upper address bits are ignored, so loads wrap within one page. Positions that were never loaded hold FFh and leave the array unchanged.
- R3: A command with `cmd_op` = 2'b01 programs the page selected by `cmd_addr[AW-1:7]`. Each byte of that page becomes its stored value ANDed with the matching staged byte.
- R4: When a program operation completes, every position of the staging buffer returns to FFh.
- R5: A command with `cmd_op` = 2'b10 sets every byte of the sector selected by the top address bits of `cmd_addr` (bits 10:9 by default) to FFh. Bytes in other sectors are left unchanged.
- R6: A command with `cmd_op` = 2'b11 sets every byte of the array to FFh. `cmd_op` = 2'b00 does nothing.
- R7: After an accepted command, `busy` stays high for exactly T_PROG, T_SECTOR or T_BULK cycles, according to the operation. If a count is smaller than the number of bytes the operation must walk, the byte count is used instead.
- R8: `done` is high for exactly one cycle: the first cycle in which `busy` is low after having been high.
- R9: While `busy` is high, commands and staging-buffer loads are ignored.
- R10: A high `rd_en` returns the byte at the read pointer on `rd_data`, with `rd_valid` high, in the next cycle, and the pointer then advances by one. The pointer wraps from the last address to 0. A high `rd_set` loads `rd_addr` first, so a read issued in the same cycle uses `rd_addr`.
- R11: While `busy` is high, a read returns 00h with `rd_valid` high, and `rd_set` and `rd_en` leave the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Write one byte into the staging buffer |
| ld_addr | input | AW | Buffer position; only bits 6:0 are used |
| ld_data | input | 8 | Byte to stage |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 none, 01 program, 10 sector erase, 11 bulk erase |
| cmd_addr | input | AW | Target page or sector address |
| rd_set | input | 1 | Load the read pointer |
| rd_addr | input | AW | New read pointer value |
| rd_en | input | 1 | Read one byte and advance the pointer |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when `busy` falls |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` is valid |

## Verification
A wrong walk base, length or index shows up only on a later read, as stray FFh bytes or as surviving old data in a neighbouring page or sector. For that reason the bench reads back bytes inside and just outside every operation it performs. A staging buffer that is not cleared, or that accepts loads while busy, first appears on the next program, when a byte is ANDed down unexpectedly. A countdown that is off by one appears at once in the measured length of `busy` and in where the `done` pulse lands. A pointer fault shows on the very next `rd_valid` cycle.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SERASE = 2'b10,
        OP_BERASE = 2'b11
    } op_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pflash_array.sv
module pflash_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Single port: write on the clock, read combinationally from the same address
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pflash_pagebuf.sv
module pflash_pagebuf
    import pflash_pkg::*;
#(
    parameter int BYTES = 128,
    parameter int PW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [PW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] ridx,
    output logic [7:0]    rdata
);

    logic [7:0] buf_d [BYTES];
    logic [7:0] buf_q [BYTES];

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            buf_d[i] = clr ? ERASED_BYTE : buf_q[i];
        end
        if (wr && !clr) begin
            buf_d[widx] = wdata;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[g] <= ERASED_BYTE;
            end else begin
                buf_q[g] <= buf_d[g];
            end
        end
    end

    assign rdata = buf_q[ridx];

endmodule

// File: rtl/pflash_rdport.sv
module pflash_rdport #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          en,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [7:0]    data;
        logic          valid;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        mem_addr   = set ? set_addr : rd_q.ptr;
        rd_d.valid = en;
        rd_d.data  = 8'h00;
        if (!busy) begin
            if (en) begin
                rd_d.data = mem_rdata;
                rd_d.ptr  = mem_addr + AW'(1);
            end else if (set) begin
                rd_d.ptr  = set_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
    import pflash_pkg::*;
#(
    parameter int PAGE_BYTES       = 128,
    parameter int PAGES_PER_SECTOR = 4,
    parameter int SECTORS          = 4,
    parameter int T_PROG           = 200,
    parameter int T_SECTOR         = 600,
    parameter int T_BULK           = 2100,
    localparam int AW = $clog2(PAGE_BYTES * PAGES_PER_SECTOR * SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          rd_set,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_en,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);

    localparam int SECTOR_BYTES = PAGE_BYTES * PAGES_PER_SECTOR;
    localparam int ARRAY_BYTES  = SECTOR_BYTES * SECTORS;
    localparam int PW           = $clog2(PAGE_BYTES);
    // A busy window never ends before the walk has touched every byte it owns
    localparam int CYC_PROG     = (T_PROG   > PAGE_BYTES)   ? T_PROG   : PAGE_BYTES;
    localparam int CYC_SECTOR   = (T_SECTOR > SECTOR_BYTES) ? T_SECTOR : SECTOR_BYTES;
    localparam int CYC_BULK     = (T_BULK   > ARRAY_BYTES)  ? T_BULK   : ARRAY_BYTES;
    localparam int CYC_INIT     = ARRAY_BYTES;
    localparam int CYC_M1       = (CYC_PROG > CYC_SECTOR) ? CYC_PROG : CYC_SECTOR;
    localparam int CYC_M2       = (CYC_BULK > CYC_INIT) ? CYC_BULK : CYC_INIT;
    localparam int CYC_MAX      = (CYC_M1 > CYC_M2) ? CYC_M1 : CYC_M2;
    localparam int CW           = $clog2(CYC_MAX + 1);
    localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] SEC_MASK  = ~AW'(SECTOR_BYTES - 1);

    typedef struct packed {
        logic          run;
        op_e           op;
        logic [AW-1:0] base;
        logic [AW:0]   idx;
        logic [AW:0]   len;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          accept;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [AW-1:0] walk_addr;
    logic [AW-1:0] rd_mem_addr;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata;
    logic [7:0]    pbuf_rdata;
    logic          pbuf_clr;
    logic          pbuf_wr;
    logic          walk_is_prog;
    logic          unused_hi;

    assign unused_hi = ^ld_addr[AW-1:PW];

    always_comb begin
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        pbuf_clr     = 1'b0;
        accept       = !seq_q.run && cmd_valid && (op_e'(cmd_op) != OP_NONE);
        walk_is_prog = (seq_q.op == OP_PROG);
        ram_we       = seq_q.run && (seq_q.idx < seq_q.len);
        walk_addr    = seq_q.base + seq_q.idx[AW-1:0];
        ram_wdata    = walk_is_prog ? (ram_rdata & pbuf_rdata) : ERASED_BYTE;

        if (seq_q.run) begin
            if (seq_q.idx < seq_q.len) begin
                seq_d.idx = seq_q.idx + (AW+1)'(1);
            end
            if (seq_q.cnt == '0) begin
                seq_d.run  = 1'b0;
                seq_d.done = 1'b1;
                pbuf_clr   = walk_is_prog;
            end else begin
                seq_d.cnt = seq_q.cnt - CW'(1);
            end
        end else if (accept) begin
            seq_d.run = 1'b1;
            seq_d.op  = op_e'(cmd_op);
            seq_d.idx = '0;
            unique case (op_e'(cmd_op))
                OP_PROG: begin
                    seq_d.base = cmd_addr & PAGE_MASK;
                    seq_d.len  = (AW+1)'(PAGE_BYTES);
                    seq_d.cnt  = CW'(CYC_PROG - 1);
                end
                OP_SERASE: begin
                    seq_d.base = cmd_addr & SEC_MASK;
                    seq_d.len  = (AW+1)'(SECTOR_BYTES);
                    seq_d.cnt  = CW'(CYC_SECTOR - 1);
                end
                default: begin
                    seq_d.base = '0;
                    seq_d.len  = (AW+1)'(ARRAY_BYTES);
                    seq_d.cnt  = CW'(CYC_BULK - 1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // Reset starts an erase sweep over the whole RAM
            seq_q.run  <= 1'b1;
            seq_q.op   <= OP_BERASE;
            seq_q.base <= '0;
            seq_q.idx  <= '0;
            seq_q.len  <= (AW+1)'(ARRAY_BYTES);
            seq_q.cnt  <= CW'(CYC_INIT - 1);
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pbuf_wr  = ld_valid && !seq_q.run;
    assign ram_addr = seq_q.run ? walk_addr : rd_mem_addr;
    assign busy     = seq_q.run;
    assign done     = seq_q.done;

    pflash_array #(
        .DEPTH (ARRAY_BYTES),
        .AW    (AW)
    ) i_array (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    pflash_pagebuf #(
        .BYTES (PAGE_BYTES),
        .PW    (PW)
    ) i_pagebuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pbuf_clr),
        .wr    (pbuf_wr),
        .widx  (ld_addr[PW-1:0]),
        .wdata (ld_data),
        .ridx  (seq_q.idx[PW-1:0]),
        .rdata (pbuf_rdata)
    );

    pflash_rdport #(
        .AW (AW)
    ) i_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (seq_q.run),
        .set       (rd_set),
        .set_addr  (rd_addr),
        .en        (rd_en),
        .mem_rdata (ram_rdata),
        .mem_addr  (rd_mem_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/pflash_ctrl_chk.sv
module pflash_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       rd_en,
    input logic       rd_valid,
    input logic [7:0] rd_data
);

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8

    AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_RD_ZERO_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy)) |-> (rd_data == 8'h00)); // R11

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && (cmd_op != 2'b00))); // R9

    AST_RD_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R10

endmodule

bind pflash_ctrl pflash_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/test_pflash_ctrl.sv
module test_pflash_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int ARRAY      = 2048;
    localparam int TP         = 200;
    localparam int TS         = 600;
    localparam int TB         = 2100;

    localparam logic [2:0] K_LOAD = 3'd0, K_PROG = 3'd1, K_SERASE = 3'd2,
                           K_BERASE = 3'd3, K_READ = 3'd4, K_NEXT = 3'd5;

    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [7:0]    val;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VECS [NVEC] = '{
        '{K_LOAD,   11'h005, 8'hA5}, '{K_LOAD,   11'h006, 8'h3C},
        '{K_PROG,   11'h000, 8'h00}, '{K_READ,   11'h005, 8'hA5},
        '{K_NEXT,   11'h000, 8'h3C}, '{K_NEXT,   11'h000, 8'hFF},
        '{K_READ,   11'h004, 8'hFF}, '{K_LOAD,   11'h287, 8'h5A},
        '{K_PROG,   11'h080, 8'h00}, '{K_READ,   11'h087, 8'h5A},
        '{K_READ,   11'h287, 8'hFF}, '{K_LOAD,   11'h005, 8'h0F},
        '{K_PROG,   11'h000, 8'h00}, '{K_READ,   11'h005, 8'h05},
        '{K_NEXT,   11'h000, 8'h3C}, '{K_LOAD,   11'h200, 8'h11},
        '{K_PROG,   11'h200, 8'h00}, '{K_READ,   11'h200, 8'h11},
        '{K_SERASE, 11'h000, 8'h00}, '{K_READ,   11'h005, 8'hFF},
        '{K_READ,   11'h087, 8'hFF}, '{K_READ,   11'h200, 8'h11},
        '{K_BERASE, 11'h000, 8'h00}, '{K_READ,   11'h200, 8'hFF},
        '{K_LOAD,   11'h7FF, 8'h77}, '{K_LOAD,   11'h000, 8'h88},
        '{K_PROG,   11'h7A5, 8'h00}, '{K_READ,   11'h7FF, 8'h77},
        '{K_NEXT,   11'h000, 8'hFF}, '{K_READ,   11'h780, 8'h88}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          rd_set = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_en = 1'b0;
    logic          busy, done, rd_valid;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    pflash_ctrl #(
        .PAGE_BYTES (128), .PAGES_PER_SECTOR (4), .SECTORS (4),
        .T_PROG (TP), .T_SECTOR (TS), .T_BULK (TB)
    ) i_pflash_ctrl (
        .clk (clk), .rst_n (rst_n),
        .ld_valid (ld_valid), .ld_addr (ld_addr), .ld_data (ld_data),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_addr (cmd_addr),
        .rd_set (rd_set), .rd_addr (rd_addr), .rd_en (rd_en),
        .busy (busy), .done (done), .rd_data (rd_data), .rd_valid (rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic command(input logic [1:0] op, input logic [AW-1:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic rd(input logic set, input logic [AW-1:0] a, input logic [7:0] exp,
                      input string req);
        rd_set = set; rd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_set = 1'b0; rd_en = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " rd_data"}, int'(rd_data), int'(exp));
    endtask

    // Counts busy cycles from the current sample point, then checks the done pulse
    task automatic wait_idle(input int exp, input string req);
        int n = 0;
        while (busy && n < 10000) begin
            n++;
            @(negedge clk);
        end
        check({req, " busy length R7"}, n, exp);
        check("R8 done on busy fall", int'(done), 1);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and initial sweep
        check("R1 busy after reset", int'(busy), 1);
        check("R1 done after reset", int'(done), 0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        wait_idle(ARRAY, "R1 init");

        // Vector walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].kind)
                K_LOAD:   load(VECS[i].addr, VECS[i].val);
                K_PROG:   begin command(2'b01, VECS[i].addr); wait_idle(TP, "R3 program"); end
                K_SERASE: begin command(2'b10, VECS[i].addr); wait_idle(TS, "R5 sector erase"); end
                K_BERASE: begin command(2'b11, VECS[i].addr); wait_idle(TB, "R6 bulk erase"); end
                K_READ:   rd(1'b1, VECS[i].addr, VECS[i].val, $sformatf("R2/R3/R4/R5/R6 vec %0d", i));
                default:  rd(1'b0, VECS[i].addr, VECS[i].val, $sformatf("R10 next vec %0d", i));
            endcase
        end

        // R6: op 00 starts nothing
        command(2'b00, 11'h000);
        check("R6 no-op keeps idle", int'(busy), 0);

        // R9 R11: activity while a sector erase runs
        load(11'h200, 8'h11);
        load(11'h201, 8'h22);
        command(2'b01, 11'h200);
        wait_idle(TP, "R3 program");
        rd(1'b1, 11'h200, 8'h11, "R10 set and read");
        command(2'b10, 11'h000);
        load(11'h300, 8'h00);
        command(2'b10, 11'h200);
        command(2'b01, 11'h300);
        rd(1'b1, 11'h400, 8'h00, "R11 read while busy");
        wait_idle(TS - 4, "R9 sector erase");
        rd(1'b0, 11'h000, 8'h22, "R11 pointer kept, R9 erase rejected");
        rd(1'b1, 11'h200, 8'h11, "R9 sector 1 intact");
        command(2'b01, 11'h300);
        wait_idle(TP, "R3 program");
        rd(1'b1, 11'h300, 8'hFF, "R9 load ignored while busy");
        rd(1'b1, 11'h000, 8'hFF, "R5 erased sector 0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule